// File: doc/BRIEF.md
# Bus Breakpoint Comparator

This block watches a processor's address and data buses during debug. Software loads a target address and, if wanted, a target data byte through a small register window. When an enabled comparison matches on a valid bus cycle, the unit latches a hit and pulls its active-low non-maskable interrupt line low. The hit, and the low interrupt line, stay in place until the monitor program writes the control register.

The register window has sixteen locations, selected by a 4-bit index:

- Locations 0 and 1 hold the low and high bytes of the 16-bit target address.
- Location 4 holds the target data byte.
- Location 15 holds the control register.
- Every other location is reserved.

Control bits:

- Bit 0 arms the unit.
- Bit 1 adds the data comparison to the address comparison.
- Bit 6 reads back the latched hit.
- Bit 7, when written together with bit 0, forces a hit by hand.

Read data comes back one clock after the index is presented.

Top module: `bpk_breakpoint`

## Requirements
- R1: After reset every register reads zero, the unit is disarmed and `nmi_n` is high.
- R2: A write to location 0, 1 or 4 stores the byte, and a later read of that location returns it. Locations 0 and 1 form the target address as {loc1, loc0}. Read data appears on `cfg_rdata` in the cycle after the index is presented.
- R3: Every location other than 0, 1, 4 and 15 reads zero. A write there changes no register.
- R4: When armed (control bit 0 = 1) and address-only (control bit 1 = 0), a cycle with `bus_vld` high and `bus_addr` equal to the target sets the hit. `nmi_n` goes low in the next cycle.
- R5: No hit is set while `bus_vld` is low, while the address differs, or while the unit is disarmed.
- R6: With control bit 1 = 1, a hit also needs `bus_done` high and `bus_data` equal to the target byte in the same cycle.
- R7: Once set, the hit stays set and `nmi_n` stays low through any bus activity, including further matches, until the control register is written.
- R8: A write to the control register clears the latched hit, and `nmi_n` returns high in the next cycle. This holds unless the same cycle sets a new hit.
- R9: Writing control with bit 7 = 1 and bit 0 = 1 forces a hit at once. Writing bit 7 = 1 with bit 0 = 0 forces nothing.
- R10: A read of control returns bit 0 and bit 1 as last written and bit 6 as the hit state. All other bits, bit 7 included, read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sel | input | 4 | Register window index |
| cfg_wr | input | 1 | Write strobe for the indexed register |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Registered read data, valid one cycle after the index |
| bus_addr | input | 16 | Watched address bus |
| bus_data | input | 8 | Watched data bus |
| bus_vld | input | 1 | High when the address bus carries a valid cycle |
| bus_done | input | 1 | High in the cycle where the data bus is complete |
| nmi_n | output | 1 | Active-low interrupt, low while a hit is latched |

## Verification
The hardest situation to reach is a data-mode cycle where the address already matches but the cycle is not yet qualified. In one such cycle `bus_done` is low. In another, `bus_done` is high but the data byte is wrong. The stimulus sets the target address, turns on data mode, and replays the same address with each of those two defects before sending the fully matching cycle. An `nmi_n` fall on either defective cycle is therefore reported. The manual trigger is driven both with and without the arm bit in the written value. This shows that the gate depends on the written enable bit.

// File: rtl/bpk_pkg.sv
package bpk_pkg;
  // register window locations whose position software relies on
  localparam int unsigned OFS_DATA = 4;
  localparam int unsigned OFS_CTRL = 15;
  // control bit positions
  localparam int unsigned CB_EN     = 0;
  localparam int unsigned CB_DMATCH = 1;
  localparam int unsigned CB_HIT    = 6;
  localparam int unsigned CB_FORCE  = 7;

  typedef struct packed {
    logic en;
    logic dmatch;
  } bpk_mode_t;
endpackage

// File: rtl/bpk_regs.sv
module bpk_regs
  import bpk_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned REG_W  = 8,
  parameter int unsigned SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic              cfg_wr,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic              hit_q,
  output logic [ADDR_W-1:0] match_addr,
  output logic [REG_W-1:0]  match_data,
  output bpk_mode_t         mode,
  output logic              ctrl_wr,
  output logic              force_req,
  output logic [REG_W-1:0]  cfg_rdata
);
  localparam int unsigned N_AB = ADDR_W / REG_W;

  logic [REG_W-1:0] abyte [N_AB];
  logic [REG_W-1:0] rd_d;
  logic             rsvd_sel;

  assign ctrl_wr   = cfg_wr && (cfg_sel == SEL_W'(OFS_CTRL));
  assign force_req = ctrl_wr && cfg_wdata[CB_FORCE] && cfg_wdata[CB_EN];

  // address bytes, one register per byte lane
  for (genvar b = 0; b < N_AB; b++) begin : g_abyte
    always_ff @(posedge clk) begin
      if (rst) abyte[b] <= '0;
      else if (cfg_wr && cfg_sel == SEL_W'(b)) abyte[b] <= cfg_wdata;
    end
    assign match_addr[b*REG_W +: REG_W] = abyte[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_data <= '0;
      mode       <= '0;
    end else begin
      if (cfg_wr && cfg_sel == SEL_W'(OFS_DATA)) match_data <= cfg_wdata;
      if (ctrl_wr) begin
        mode.en     <= cfg_wdata[CB_EN];
        mode.dmatch <= cfg_wdata[CB_DMATCH];
      end
    end
  end

  always_comb begin
    rd_d     = '0;
    rsvd_sel = 1'b1;
    for (int i = 0; i < N_AB; i++) begin
      if (cfg_sel == SEL_W'(i)) begin
        rd_d     = abyte[i];
        rsvd_sel = 1'b0;
      end
    end
    if (cfg_sel == SEL_W'(OFS_DATA)) begin
      rd_d     = match_data;
      rsvd_sel = 1'b0;
    end
    if (cfg_sel == SEL_W'(OFS_CTRL)) begin
      rd_d            = '0;
      rd_d[CB_EN]     = mode.en;
      rd_d[CB_DMATCH] = mode.dmatch;
      rd_d[CB_HIT]    = hit_q;
      rsvd_sel        = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_d;
  end

  // R3
  rsvd_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rsvd_sel |=> cfg_rdata == '0);
endmodule

// File: rtl/bpk_match.sv
module bpk_match
  import bpk_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_data,
  input  logic              bus_vld,
  input  logic              bus_done,
  input  logic [ADDR_W-1:0] match_addr,
  input  logic [REG_W-1:0]  match_data,
  input  bpk_mode_t         mode,
  input  logic              ctrl_wr,
  input  logic              force_req,
  output logic              hit_q,
  output logic              nmi_n
);
  logic addr_eq, data_ok, bus_hit, hit_d;

  assign addr_eq = (bus_addr == match_addr);
  assign data_ok = !mode.dmatch || (bus_done && bus_data == match_data);
  assign bus_hit = mode.en && bus_vld && addr_eq && data_ok;
  // a new hit wins over a clear in the same cycle
  assign hit_d   = bus_hit || force_req || (hit_q && !ctrl_wr);

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= 1'b0;
      nmi_n <= 1'b1;
    end else begin
      hit_q <= hit_d;
      nmi_n <= !hit_d;
    end
  end

  // R7
  hit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    hit_q && !ctrl_wr |=> hit_q);
  // R5
  idle_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
    !hit_q && !bus_vld && !force_req |=> !hit_q);
  // R8
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    hit_q && ctrl_wr && !force_req && !bus_vld |=> !hit_q);
  // R6
  data_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !hit_q && mode.dmatch && !bus_done && !force_req |=> !hit_q);
endmodule

// File: rtl/bpk_breakpoint.sv
module bpk_breakpoint
  import bpk_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned REG_W  = 8,
  parameter int unsigned SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic              cfg_wr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_data,
  input  logic              bus_vld,
  input  logic              bus_done,
  output logic              nmi_n
);
  logic [ADDR_W-1:0] match_addr;
  logic [REG_W-1:0]  match_data;
  bpk_mode_t         mode;
  logic              ctrl_wr, force_req, hit_q;

  bpk_regs #(.ADDR_W(ADDR_W), .REG_W(REG_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .hit_q(hit_q), .match_addr(match_addr),
    .match_data(match_data), .mode(mode), .ctrl_wr(ctrl_wr),
    .force_req(force_req), .cfg_rdata(cfg_rdata)
  );

  bpk_match #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_match (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_vld(bus_vld), .bus_done(bus_done), .match_addr(match_addr),
    .match_data(match_data), .mode(mode), .ctrl_wr(ctrl_wr),
    .force_req(force_req), .hit_q(hit_q), .nmi_n(nmi_n)
  );

  // R1
  nmi_tracks_hit_chk: assert property (@(posedge clk) disable iff (rst)
    nmi_n == !hit_q);
endmodule

// File: tb/test_bpk_breakpoint.sv
module test_bpk_breakpoint;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cfg_sel = '0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic        bus_vld = 1'b0;
  logic        bus_done = 1'b0;
  logic        nmi_n;

  int unsigned cyc = 0;
  int unsigned errors = 0;
  int unsigned checks = 0;
  bit          finished = 1'b0;

  typedef struct {
    int unsigned due;
    bit          is_nmi;
    logic [7:0]  exp;
    string       tag;
  } item_t;
  item_t sbq[$];

  bpk_breakpoint i_bpk_breakpoint (
    .clk(clk), .rst(rst), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_vld(bus_vld), .bus_done(bus_done),
    .nmi_n(nmi_n)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops due items at the falling edge
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      item_t it;
      logic [7:0] act;
      it = sbq.pop_front();
      act = it.is_nmi ? {7'd0, nmi_n} : cfg_rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: %s actual=%h expected=%h", it.tag,
                 it.is_nmi ? "nmi_n" : "rdata", act, it.exp);
      end
    end
  end

  task automatic drv(input logic [3:0] sel, input logic wr, input logic [7:0] wd,
                     input logic [15:0] a, input logic [7:0] d,
                     input logic v, input logic dn);
    @(posedge clk); #1;
    cfg_sel = sel; cfg_wr = wr; cfg_wdata = wd;
    bus_addr = a; bus_data = d; bus_vld = v; bus_done = dn;
  endtask

  task automatic push(input bit is_nmi, input logic [7:0] e, input string tag);
    item_t it;
    it.due = cyc + 1; it.is_nmi = is_nmi; it.exp = e; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic wr_reg(input logic [3:0] sel, input logic [7:0] v);
    drv(sel, 1'b1, v, 16'h0, 8'h0, 1'b0, 1'b0);
  endtask

  task automatic rd_chk(input logic [3:0] sel, input logic [7:0] e, input string tag);
    drv(sel, 1'b0, 8'h0, 16'h0, 8'h0, 1'b0, 1'b0);
    push(1'b0, e, tag);
  endtask

  task automatic bus_chk(input logic [15:0] a, input logic [7:0] d, input logic v,
                         input logic dn, input logic e_nmi, input string tag);
    drv(4'h0, 1'b0, 8'h0, a, d, v, dn);
    push(1'b1, {7'd0, e_nmi}, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    rd_chk(4'h0, 8'h00, "R1 addr lo");
    rd_chk(4'h1, 8'h00, "R1 addr hi");
    rd_chk(4'h4, 8'h00, "R1 data");
    rd_chk(4'hF, 8'h00, "R1 ctrl");
    push(1'b1, 8'h01, "R1 nmi high");
    // R2 register storage
    wr_reg(4'h0, 8'h34);
    wr_reg(4'h1, 8'h12);
    wr_reg(4'h4, 8'hA5);
    rd_chk(4'h0, 8'h34, "R2 addr lo");
    rd_chk(4'h1, 8'h12, "R2 addr hi");
    rd_chk(4'h4, 8'hA5, "R2 data");
    // R3 reserved locations
    wr_reg(4'h2, 8'hFF);
    wr_reg(4'h3, 8'hFF);
    wr_reg(4'h5, 8'hFF);
    wr_reg(4'h9, 8'hFF);
    wr_reg(4'hE, 8'hFF);
    rd_chk(4'h2, 8'h00, "R3 loc2");
    rd_chk(4'h3, 8'h00, "R3 loc3");
    rd_chk(4'h7, 8'h00, "R3 loc7");
    rd_chk(4'hE, 8'h00, "R3 locE");
    rd_chk(4'h0, 8'h34, "R3 lo untouched");
    rd_chk(4'h4, 8'hA5, "R3 data untouched");
    rd_chk(4'hF, 8'h00, "R3 ctrl untouched");
    // R5 disarmed
    bus_chk(16'h1234, 8'h00, 1'b1, 1'b1, 1'b1, "R5 disarmed");
    // R4 address-only
    wr_reg(4'hF, 8'h01);
    bus_chk(16'h1234, 8'h00, 1'b0, 1'b0, 1'b1, "R5 no valid strobe");
    bus_chk(16'h1235, 8'h00, 1'b1, 1'b0, 1'b1, "R5 address differs");
    bus_chk(16'h3412, 8'h00, 1'b1, 1'b0, 1'b1, "R5 swapped bytes");
    bus_chk(16'h1234, 8'h00, 1'b1, 1'b0, 1'b0, "R4 match");
    // R7 latched
    bus_chk(16'h0000, 8'h00, 1'b0, 1'b0, 1'b0, "R7 held idle");
    bus_chk(16'h1234, 8'h00, 1'b1, 1'b0, 1'b0, "R7 held rematch");
    rd_chk(4'hF, 8'h41, "R10 R7 ctrl hit");
    // R8 clear
    wr_reg(4'hF, 8'h00);
    push(1'b1, 8'h01, "R8 cleared");
    rd_chk(4'hF, 8'h00, "R8 ctrl after clear");
    // R6 data mode
    wr_reg(4'hF, 8'h03);
    bus_chk(16'h1234, 8'hA5, 1'b1, 1'b0, 1'b1, "R6 not done");
    bus_chk(16'h1234, 8'h5A, 1'b1, 1'b1, 1'b1, "R6 wrong data");
    bus_chk(16'h1235, 8'hA5, 1'b1, 1'b1, 1'b1, "R6 wrong addr");
    bus_chk(16'h1234, 8'hA5, 1'b1, 1'b1, 1'b0, "R6 full match");
    rd_chk(4'hF, 8'h43, "R10 ctrl data mode hit");
    // R9 force gated by arm bit
    wr_reg(4'hF, 8'h80);
    push(1'b1, 8'h01, "R9 force without arm");
    rd_chk(4'hF, 8'h00, "R10 bit7 reads zero");
    bus_chk(16'h0000, 8'h00, 1'b0, 1'b0, 1'b1, "R9 still high");
    wr_reg(4'hF, 8'h81);
    push(1'b1, 8'h00, "R9 forced");
    rd_chk(4'hF, 8'h41, "R10 forced hit");
    wr_reg(4'hF, 8'h01);
    push(1'b1, 8'h01, "R8 clear after force");
    drv(4'h0, 1'b0, 8'h0, 16'h0, 8'h0, 1'b0, 1'b0);
    repeat (4) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule